// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block gathers 64 interrupt request lines into two 32-bit register banks, named high and low. Each bank has a mask register and a pending register. The position of a source inside the banks does not follow its number. A fixed permutation places each source, and software must use that table to find the bit it wants. Most sources are internal, active-low level requests. Two groups have a programmable sense, selected through a shared edge-select register:
- Seven external lines can be set to falling edge or to level.
- Sixteen port lines can be set to falling edge only or to both edges.

A CPU reads and writes the registers over a simple 32-bit word bus with a one-cycle registered read. It unmasks the sources it services, clears latched edge events by writing ones, and reads a vector register to learn the number of the highest-priority active source. A single registered line tells the CPU that at least one unmasked source is pending. Priority is fixed: the lowest source number wins.

Top module: `scram_irq_ctrl`

## Requirements
- R1: After reset, both mask registers, both pending registers, the edge-select register and the vector read back as 0, and `cpu_irq` is low.
- R2: Source s maps to one bank and one bit:

  | Sources | Bank | Bit |
  |---|---|---|
  | 0 | low | 0 |
  | 1–15 | low | 16−s |
  | 16–18 | high | 18−s |
  | 19–30 | high | 33−s |
  | 32–47 | low | 63−s |
  | 48–63 | high | s−32 |

  Pending and mask bits use this same placement.
- R3: Mask registers are fully writable and read back what was written. A mask bit of 1 enables its source. `cpu_irq` is high exactly when some pending bit has its mask bit set. It follows the register state with one cycle of delay.
- R4: Writes to a pending register clear the latched edge events whose bits are written as 1. Bits written as 0 have no effect.
- R5: Internal sources are active-low level. Their pending bit follows the inverted input, and writing ones cannot clear it while the input is held low.
- R6: External sources 19–25 have an edge-select bit at position 33−s.
  - Select 1 latches a falling edge until it is cleared.
  - Select 0 makes the source active-low level.
- R7: Port sources 48–63 have an edge-select bit at position s−32.
  - Select 1 latches only falling edges.
  - Select 0 latches both rising and falling edges.
- R8: Reading the vector returns the number of the lowest-numbered active (pending and unmasked) source in bits 31:26, with bits 25:0 zero. With no active source it reads 0.
- R9: Word offsets are:

  | Offset | Register |
  |---|---|
  | 0x00 | mask high |
  | 0x04 | mask low |
  | 0x08 | pending high |
  | 0x0C | pending low |
  | 0x10 | edge select |
  | 0x14 | vector |

  Writes to the vector offset change no register.
- R10: Source 31 has no bit and never becomes pending. High-bank pending bit 15 always reads 0.
- R11: An input change reaches the pending register on the third rising edge after it is applied, through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_n | input | 64 | Interrupt request lines, active low, indexed by source number |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid on the next cycle |
| addr | input | 5 | Byte address of the register (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
Every mappable source is asserted in turn and its pending bit is read back from the expected bank. A design with a single entry of the permutation wrong reports the source in the wrong place or produces a wrong vector number.

Edge and level behaviour is checked through these cases:
- An edge latch that vanished when its input was released, or a level bit that a write of ones could clear, would show a stale or missing pending bit.
- A port line in falling-only mode that latched a rising edge would leave a pending bit set after release.

Priority is tested with two active sources, then with the winner removed. Writes to the vector offset, and the unmapped source 31, are checked to leave every register unchanged and `cpu_irq` low.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int NSRC  = 64;
  localparam int SRC_W = 6;

  typedef enum logic [1:0] {
    K_INT  = 2'd0,
    K_EXT  = 2'd1,
    K_PORT = 2'd2,
    K_NONE = 2'd3
  } kind_e;

  // sense group of a source
  function automatic kind_e src_kind(input int s);
    if (s == 31)               return K_NONE;
    if (s >= 19 && s <= 25)    return K_EXT;
    if (s >= 48)               return K_PORT;
    return K_INT;
  endfunction

  // 1 when the source lives in the high bank
  function automatic logic src_hi(input int s);
    return ((s >= 16 && s <= 31) || s >= 48) ? 1'b1 : 1'b0;
  endfunction

  // bit position inside its bank (permuted placement)
  function automatic int src_bit(input int s);
    if (s == 0)  return 0;
    if (s < 16)  return 16 - s;
    if (s <= 18) return 18 - s;
    if (s <= 30) return 33 - s;
    if (s == 31) return 15;
    if (s < 48)  return 63 - s;
    return s - 32;
  endfunction

  // position of the sense-select bit in the edge register
  function automatic int src_edge_bit(input int s);
    if (s >= 19 && s <= 25) return 33 - s;
    if (s >= 48)            return s - 32;
    return 0;
  endfunction

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
  parameter int NSRC   = 64,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_n,
  output logic [NSRC-1:0] lvl,
  output logic [NSRC-1:0] fall,
  output logic [NSRC-1:0] rise
);

  // stg[STAGES-1] is the synchronized value, stg[STAGES] its previous cycle
  logic [NSRC-1:0] stg [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= src_n;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl  = ~stg[STAGES-1];
  assign fall = stg[STAGES] & ~stg[STAGES-1];
  assign rise = ~stg[STAGES] & stg[STAGES-1];

endmodule

// File: rtl/sirq_pend.sv
module sirq_pend
  import sirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   lvl,
  input  logic [NSRC-1:0]   fall,
  input  logic [NSRC-1:0]   rise,
  input  logic [DATA_W-1:0] edge_sel,
  input  logic [DATA_W-1:0] clr_hi,
  input  logic [DATA_W-1:0] clr_lo,
  output logic [NSRC-1:0]   psrc,
  output logic [DATA_W-1:0] pend_hi,
  output logic [DATA_W-1:0] pend_lo
);

  logic unused_in;
  assign unused_in = ^{lvl, fall, rise, edge_sel, clr_hi, clr_lo};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam kind_e K  = src_kind(s);
    localparam int    B  = src_bit(s);
    localparam logic  HI = src_hi(s);
    localparam int    EB = src_edge_bit(s);

    if (K == K_NONE) begin : g_none
      assign psrc[s] = 1'b0;
    end else begin : g_live
      logic p, clr, use_edge, hit;

      assign clr = HI ? clr_hi[B] : clr_lo[B];

      if (K == K_INT) begin : g_int
        assign use_edge = 1'b0;
        assign hit      = 1'b0;
      end else if (K == K_EXT) begin : g_ext
        assign use_edge = edge_sel[EB];
        assign hit      = fall[s];
      end else begin : g_port
        assign use_edge = 1'b1;
        assign hit      = fall[s] | (~edge_sel[EB] & rise[s]);
      end

      always_ff @(posedge clk) begin
        if (rst)           p <= 1'b0;
        else if (use_edge) p <= (p & ~clr) | hit;
        else               p <= lvl[s];
      end

      assign psrc[s] = p;
    end
  end

  // gather per-source state into the two register banks
  always_comb begin
    pend_hi = '0;
    pend_lo = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_kind(s) != K_NONE) begin
        if (src_hi(s)) pend_hi[src_bit(s)] = psrc[s];
        else           pend_lo[src_bit(s)] = psrc[s];
      end
    end
  end

endmodule

// File: rtl/sirq_prio.sv
module sirq_prio
  import sirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NSRC-1:0]   psrc,
  input  logic [DATA_W-1:0] mask_hi,
  input  logic [DATA_W-1:0] mask_lo,
  output logic              any,
  output logic [SRC_W-1:0]  win
);

  logic [NSRC-1:0] active;
  logic            unused_msk;
  assign unused_msk = ^{mask_hi, mask_lo};

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      if (src_kind(s) == K_NONE) active[s] = 1'b0;
      else if (src_hi(s))        active[s] = psrc[s] & mask_hi[src_bit(s)];
      else                       active[s] = psrc[s] & mask_lo[src_bit(s)];
    end
  end

  // lowest source number wins
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (active[s]) begin
        any = 1'b1;
        win = SRC_W'(s);
      end
    end
  end

endmodule

// File: rtl/scram_irq_ctrl.sv
module scram_irq_ctrl
  import sirq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       src_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cpu_irq
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] W_MASK_HI = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_MASK_LO = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_PEND_HI = IDX_W'(2);
  localparam logic [IDX_W-1:0] W_PEND_LO = IDX_W'(3);
  localparam logic [IDX_W-1:0] W_EDGE    = IDX_W'(4);
  localparam logic [IDX_W-1:0] W_VEC     = IDX_W'(5);

  logic [IDX_W-1:0]  idx;
  logic              unused_lsb;
  logic [DATA_W-1:0] mask_hi, mask_lo, edge_r;
  logic [DATA_W-1:0] clr_hi, clr_lo, pend_hi, pend_lo;
  logic [NSRC-1:0]   lvl, fall, rise, psrc;
  logic              any;
  logic [SRC_W-1:0]  win;
  logic [DATA_W-1:0] vec_word;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  sirq_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .src_n(src_n),
    .lvl  (lvl),
    .fall (fall),
    .rise (rise)
  );

  assign clr_hi = (wr_en && idx == W_PEND_HI) ? wdata : '0;
  assign clr_lo = (wr_en && idx == W_PEND_LO) ? wdata : '0;

  sirq_pend #(.DATA_W(DATA_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .lvl     (lvl),
    .fall    (fall),
    .rise    (rise),
    .edge_sel(edge_r),
    .clr_hi  (clr_hi),
    .clr_lo  (clr_lo),
    .psrc    (psrc),
    .pend_hi (pend_hi),
    .pend_lo (pend_lo)
  );

  sirq_prio #(.DATA_W(DATA_W)) u_prio (
    .psrc   (psrc),
    .mask_hi(mask_hi),
    .mask_lo(mask_lo),
    .any    (any),
    .win    (win)
  );

  assign vec_word = any ? {win, {(DATA_W-SRC_W){1'b0}}} : '0;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_hi <= '0;
      mask_lo <= '0;
      edge_r  <= '0;
    end else if (wr_en) begin
      case (idx)
        W_MASK_HI: mask_hi <= wdata;
        W_MASK_LO: mask_lo <= wdata;
        W_EDGE:    edge_r  <= wdata;
        default: ;
      endcase
    end
  end

  // registered read port and CPU request
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      cpu_irq <= 1'b0;
    end else begin
      cpu_irq <= any;
      if (rd_en) begin
        case (idx)
          W_MASK_HI: rdata <= mask_hi;
          W_MASK_LO: rdata <= mask_lo;
          W_PEND_HI: rdata <= pend_hi;
          W_PEND_LO: rdata <= pend_lo;
          W_EDGE:    rdata <= edge_r;
          W_VEC:     rdata <= vec_word;
          default:   rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/scram_irq_ctrl_chk.sv
module scram_irq_ctrl_chk
  import sirq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              cpu_irq,
  input logic [DATA_W-1:0] mask_hi,
  input logic [DATA_W-1:0] mask_lo,
  input logic [DATA_W-1:0] edge_r,
  input logic [DATA_W-1:0] pend_hi,
  input logic [DATA_W-1:0] pend_lo
);

  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] a_idx;
  assign a_idx = addr[ADDR_W-1:2];

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_hi == '0 && mask_lo == '0 && edge_r == '0 && !cpu_irq));

  assert_irq_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == $past(|((pend_hi & mask_hi) | (pend_lo & mask_lo))));

  assert_mask_write_R3: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && a_idx == IDX_W'(0)) |-> mask_hi == $past(wdata));

  assert_vec_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && a_idx == IDX_W'(5)) |-> rdata[DATA_W-SRC_W-1:0] == '0);

  assert_vec_readonly_R9: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && a_idx == IDX_W'(5)) |->
      (mask_hi == $past(mask_hi) && mask_lo == $past(mask_lo) && edge_r == $past(edge_r)));

endmodule

bind scram_irq_ctrl scram_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .cpu_irq(cpu_irq),
  .mask_hi(mask_hi),
  .mask_lo(mask_lo),
  .edge_r (edge_r),
  .pend_hi(pend_hi),
  .pend_lo(pend_lo)
);

// File: tb/scram_irq_ctrl_bench.sv
module scram_irq_ctrl_bench;

  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [2:0] I_MH = 3'd0, I_ML = 3'd1, I_PH = 3'd2,
                         I_PL = 3'd3, I_EDG = 3'd4, I_VEC = 3'd5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [63:0]   src_n = '1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          cpu_irq;

  always #4 clk = ~clk;

  scram_irq_ctrl u_scram_irq_ctrl (
    .clk(clk), .rst(rst), .src_n(src_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_irq(cpu_irq)
  );

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  logic  rd_vld = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) rd_vld <= rd_en;

  // monitor: compares each completed read with the queued expectation
  always @(negedge clk) begin
    if (rd_vld) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read data actual %h expected none", rdata);
      end else begin
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  function automatic logic hi_of(input int s);
    return ((s >= 16 && s <= 31) || s >= 48);
  endfunction

  function automatic logic [DW-1:0] bit_of(input int s);
    int b;
    if (s == 0)       b = 0;
    else if (s < 16)  b = 16 - s;
    else if (s <= 18) b = 18 - s;
    else if (s <= 30) b = 33 - s;
    else if (s < 48)  b = 63 - s;
    else              b = s - 32;
    return DW'(1) << b;
  endfunction

  function automatic logic [DW-1:0] vec_of(input int s);
    return {6'(s), 26'd0};
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {idx, 2'b00}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: issues a read and queues the expected value
  task automatic rd(input logic [2:0] idx, input logic [DW-1:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = {idx, 2'b00};
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (cpu_irq !== e) begin
      errors++;
      $display("FAIL %s cpu_irq actual %b expected %b", tag, cpu_irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(5);
    rst = 1'b0;

    // R1: reset state
    rd(I_MH, '0, "R1 mask high");
    rd(I_ML, '0, "R1 mask low");
    rd(I_PH, '0, "R1 pend high");
    rd(I_PL, '0, "R1 pend low");
    rd(I_EDG, '0, "R1 edge");
    rd(I_VEC, '0, "R1 vector");
    chk_irq(1'b0, "R1 irq");

    // R2 R5 R11: level sources appear at permuted bits
    src_n[0] = 1'b0; src_n[5] = 1'b0; src_n[40] = 1'b0;
    src_n[17] = 1'b0; src_n[20] = 1'b0;
    settle(1);
    rd(I_PL, '0, "R11 not yet visible");
    settle(4);
    rd(I_PL, 32'h0080_0801, "R2 low bank placement");
    rd(I_PH, 32'h0000_2002, "R2 high bank placement");
    chk_irq(1'b0, "R3 all masked");
    wr(I_PL, '1);
    settle(2);
    rd(I_PL, 32'h0080_0801, "R5 level not cleared by write");

    // R3 R8: masking, priority
    wr(I_ML, 32'h0080_0000);
    settle(3);
    chk_irq(1'b1, "R3 unmasked source");
    rd(I_VEC, vec_of(40), "R8 single winner");
    wr(I_MH, 32'h0000_0002);
    settle(3);
    rd(I_VEC, vec_of(17), "R8 lower number wins");
    src_n[17] = 1'b1;
    settle(5);
    rd(I_VEC, vec_of(40), "R8 winner removed");
    src_n = '1;
    settle(5);
    rd(I_VEC, '0, "R8 none active");
    rd(I_PL, '0, "R5 level follows release");
    chk_irq(1'b0, "R3 nothing active");

    // R6 R4: external falling edge latch
    wr(I_EDG, 32'h0000_4000);
    wr(I_MH, 32'h0000_4000);
    src_n[19] = 1'b0;
    settle(4);
    src_n[19] = 1'b1;
    settle(5);
    rd(I_PH, 32'h0000_4000, "R6 edge latched after release");
    chk_irq(1'b1, "R6 edge raises irq");
    rd(I_VEC, vec_of(19), "R6 vector");
    wr(I_PH, '0);
    settle(2);
    rd(I_PH, 32'h0000_4000, "R4 zero bits keep latch");
    wr(I_PH, 32'h0000_4000);
    settle(3);
    rd(I_PH, '0, "R4 one clears latch");
    chk_irq(1'b0, "R4 irq drops");

    // R7: port both-edges vs falling-only
    wr(I_EDG, 32'h0004_4000);
    src_n[48] = 1'b0; src_n[50] = 1'b0;
    settle(5);
    rd(I_PH, 32'h0005_0000, "R7 falling edges latch");
    wr(I_PH, 32'h0005_0000);
    settle(2);
    rd(I_PH, '0, "R7 cleared");
    src_n[48] = 1'b1; src_n[50] = 1'b1;
    settle(5);
    rd(I_PH, 32'h0001_0000, "R7 rise latched only in both-edge mode");
    wr(I_PH, 32'h0001_0000);

    // R9: vector writes are ignored
    wr(I_VEC, '1);
    settle(2);
    rd(I_MH, 32'h0000_4000, "R9 mask high kept");
    rd(I_ML, 32'h0080_0000, "R9 mask low kept");
    rd(I_EDG, 32'h0004_4000, "R9 edge kept");
    rd(I_VEC, '0, "R9 vector unchanged");

    // R2 sweep over every mapped source
    wr(I_EDG, '0);
    wr(I_MH, '1);
    wr(I_ML, '1);
    rd(I_MH, '1, "R3 mask readback");
    for (int s = 0; s < 64; s++) begin
      if (s != 31) begin
        src_n[s] = 1'b0;
        settle(4);
        rd(hi_of(s) ? I_PH : I_PL, bit_of(s), $sformatf("R2 source %0d bit", s));
        rd(I_VEC, vec_of(s), $sformatf("R2 source %0d vector", s));
        src_n[s] = 1'b1;
        settle(4);
        wr(hi_of(s) ? I_PH : I_PL, bit_of(s));
        settle(2);
      end
    end

    // R10: source 31 is unmapped
    src_n[31] = 1'b0;
    settle(5);
    rd(I_PH, '0, "R10 high bank quiet");
    rd(I_PL, '0, "R10 low bank quiet");
    chk_irq(1'b0, "R10 no irq");
    src_n[31] = 1'b1;

    settle(3);
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R9 reads missing actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule